// File: doc/BRIEF.md
# UART Receive Buffer with Per-Character Error Tags

This block is the receive-side store of a UART. A deserializer pushes each received character along with its framing, parity and break flags. The block keeps them in order in a circular buffer, one 12-bit word per character. Software drains the buffer through a read strobe and polls the empty and full flags. A sticky four-bit status register collects every error condition seen since software last cleared it.

The buffer depth is a parameter. Typical values are 16 or 32. A control input turns buffering off, and the store then holds only one character. When a character arrives and no slot is free, the character is dropped. The overrun is then recorded on the newest character that is still held, and in the sticky status.

Top module: `uart_rx_tagfifo`

## Requirements
- R1: The read word carries the character in bits [7:0], framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11.
- R2: With buffering on, characters are returned in arrival order, and up to DEPTH of them are held.
- R3: `rx_empty` is high exactly when nothing is held. `rx_full` is high when the held count reaches the capacity. Both reflect a push or a pop from the clock edge that accepts it.
- R4: A push while full, with no pop accepted in the same cycle, discards the character. It also sets bit 11 of the most recently stored entry and sets the overrun status bit.
- R5: A read strobe while empty leaves the read word unchanged and consumes nothing.
- R6: Status bits [3:0] are framing, parity, break and overrun, from bit 0 up. A bit is set by an accepted push carrying that flag, and it stays set across reads.
- R7: A clear strobe zeroes the status. A flag pushed in the same cycle as the clear is kept.
- R8: With buffering off, the capacity is one entry.
- R9: A push and a pop in the same cycle while full are both accepted, with no overrun.
- R10: After reset the read word and the status are zero, `rx_empty` is high and `rx_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on | input | 1 | 1: DEPTH-entry buffer, 0: single holding entry |
| push_stb | input | 1 | Character arrival strobe |
| push_char | input | 8 | Received character |
| push_frm | input | 1 | Framing error for this character |
| push_par | input | 1 | Parity error for this character |
| push_brk | input | 1 | Break condition for this character |
| pop_stb | input | 1 | Read strobe |
| clr_stat | input | 1 | Clear strobe for the sticky status |
| rd_word | output | 12 | Last word read out, in the tagged layout |
| rx_empty | output | 1 | Buffer empty |
| rx_full | output | 1 | Buffer at capacity |
| rx_stat | output | 4 | Sticky error status |

## Verification
Every result of this block is registered once. The read word, both flags and the status all change on the same rising edge that samples the push, pop or clear strobe. None of them lags by an extra cycle.

The bench drives each strobe on the falling edge and holds it for exactly one rising edge. It samples all outputs one nanosecond after that edge. Each check therefore sees the effect of exactly one cycle's stimulus, including cycles where a push, a pop and a clear coincide.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;
   localparam int CHAR_W = 8;
   localparam int TAG_W  = 4;
   localparam int WORD_W = CHAR_W + TAG_W;

   // Entry layout, MSB first: overrun, break, parity, framing, character.
   typedef struct packed {
      logic              ovr;
      logic              brk;
      logic              par;
      logic              frm;
      logic [CHAR_W-1:0] ch;
   } rx_entry_t;

   // Sticky status layout, MSB first.
   typedef struct packed {
      logic ovr;
      logic brk;
      logic par;
      logic frm;
   } rx_stat_t;
endpackage

// File: rtl/rxtag_ctrl.sv
module rxtag_ctrl #(
   parameter int DEPTH = 32,
   parameter int PTR_W = 5,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_on,
   input  logic             push,
   input  logic             pop,
   output logic             wr_en,
   output logic             rd_en,
   output logic             ovr_hit,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] rd_idx,
   output logic [PTR_W-1:0] last_idx,
   output logic             empty,
   output logic             full
);
   localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CAP_ON  = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CAP_OFF = CNT_W'(1);

   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q, cap;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt   = wr_ptr_q + 1'b1;
         assign rd_nxt   = rd_ptr_q + 1'b1;
         assign last_idx = wr_ptr_q - 1'b1;
      end else begin : g_mod
         assign wr_nxt   = (wr_ptr_q == PTR_TOP) ? '0 : wr_ptr_q + 1'b1;
         assign rd_nxt   = (rd_ptr_q == PTR_TOP) ? '0 : rd_ptr_q + 1'b1;
         assign last_idx = (wr_ptr_q == '0) ? PTR_TOP : wr_ptr_q - 1'b1;
      end
   endgenerate

   always_comb begin
      cap     = fifo_on ? CAP_ON : CAP_OFF;
      empty   = (cnt_q == '0);
      full    = (cnt_q >= cap);
      rd_en   = pop && !empty;
      wr_en   = push && (!full || rd_en);
      ovr_hit = push && full && !rd_en;
      wr_idx  = wr_ptr_q;
      rd_idx  = rd_ptr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (wr_en) wr_ptr_q <= wr_nxt;
         if (rd_en) rd_ptr_q <= rd_nxt;
         case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/rxtag_store.sv
module rxtag_store
   import rxtag_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int PTR_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_idx,
   input  rx_entry_t        wr_data,
   input  logic             ovr_mark,
   input  logic [PTR_W-1:0] last_idx,
   input  logic             rd_en,
   input  logic [PTR_W-1:0] rd_idx,
   output rx_entry_t        rd_q
);
   rx_entry_t bank [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         rx_entry_t cell_q;
         logic      hit_wr, hit_ovr;

         assign hit_wr  = wr_en && (wr_idx == PTR_W'(i));
         assign hit_ovr = ovr_mark && (last_idx == PTR_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cell_q     <= '0;
            else if (hit_wr)  cell_q     <= wr_data;
            else if (hit_ovr) cell_q.ovr <= 1'b1;
         end

         assign bank[i] = cell_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= bank[rd_idx];
   end
endmodule

// File: rtl/rxtag_sticky.sv
module rxtag_sticky
   import rxtag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  logic     take,
   input  logic     frm,
   input  logic     par,
   input  logic     brk,
   input  logic     ovr,
   output rx_stat_t stat_q
);
   rx_stat_t hold, fresh;

   always_comb begin
      hold      = clr ? rx_stat_t'('0) : stat_q;
      fresh.frm = take && frm;
      fresh.par = take && par;
      fresh.brk = take && brk;
      fresh.ovr = ovr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= hold | fresh;
   end
endmodule

// File: rtl/uart_rx_tagfifo.sv
module uart_rx_tagfifo
   import rxtag_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_on,
   input  logic              push_stb,
   input  logic [CHAR_W-1:0] push_char,
   input  logic              push_frm,
   input  logic              push_par,
   input  logic              push_brk,
   input  logic              pop_stb,
   input  logic              clr_stat,
   output logic [WORD_W-1:0] rd_word,
   output logic              rx_empty,
   output logic              rx_full,
   output logic [TAG_W-1:0]  rx_stat
);
   generate
      if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
         $error("uart_rx_tagfifo: DEPTH must lie in 2..1024");
      end
      if ((1 << PTR_W) < DEPTH) begin : g_bad_ptr
         $error("uart_rx_tagfifo: PTR_W too narrow for DEPTH");
      end
      if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt
         $error("uart_rx_tagfifo: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic             wr_en, rd_en, ovr_hit;
   logic [PTR_W-1:0] wr_idx, rd_idx, last_idx;
   rx_entry_t        in_ent, out_ent;
   rx_stat_t         stat;

   always_comb begin
      in_ent.ovr = 1'b0;
      in_ent.brk = push_brk;
      in_ent.par = push_par;
      in_ent.frm = push_frm;
      in_ent.ch  = push_char;
   end

   rxtag_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on),
      .push(push_stb), .pop(pop_stb),
      .wr_en(wr_en), .rd_en(rd_en), .ovr_hit(ovr_hit),
      .wr_idx(wr_idx), .rd_idx(rd_idx), .last_idx(last_idx),
      .empty(rx_empty), .full(rx_full)
   );

   rxtag_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(in_ent),
      .ovr_mark(ovr_hit), .last_idx(last_idx),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_q(out_ent)
   );

   rxtag_sticky u_stat (
      .clk(clk), .rst_n(rst_n), .clr(clr_stat), .take(wr_en),
      .frm(push_frm), .par(push_par), .brk(push_brk), .ovr(ovr_hit),
      .stat_q(stat)
   );

   assign rd_word = out_ent;
   assign rx_stat = stat;
endmodule

// File: rtl/rxtag_chk.sv
module rxtag_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        fifo_on,
   input logic        push_stb,
   input logic        pop_stb,
   input logic        clr_stat,
   input logic [11:0] rd_word,
   input logic        rx_empty,
   input logic        rx_full,
   input logic [3:0]  rx_stat
);
   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty && rx_full));

   a_r2_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
      push_stb && !rx_full |=> !rx_empty);

   a_r4_overrun_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      push_stb && rx_full && !pop_stb |=> rx_full && rx_stat[3]);

   a_r5_empty_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
      pop_stb && rx_empty |=> $stable(rd_word));

   a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_stat |=> ((rx_stat & $past(rx_stat)) == $past(rx_stat)));

   a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stat && !push_stb |=> rx_stat == 4'b0000);

   a_r8_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_on && !rx_empty |-> rx_full);
endmodule

bind uart_rx_tagfifo rxtag_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .push_stb(push_stb),
   .pop_stb(pop_stb), .clr_stat(clr_stat), .rd_word(rd_word),
   .rx_empty(rx_empty), .rx_full(rx_full), .rx_stat(rx_stat)
);

// File: tb/tb_uart_rx_tagfifo.sv
module tb_uart_rx_tagfifo;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_on = 1'b1;
   logic        push_stb = 1'b0, push_frm = 1'b0, push_par = 1'b0, push_brk = 1'b0;
   logic [7:0]  push_char = '0;
   logic        pop_stb = 1'b0, clr_stat = 1'b0;
   logic [11:0] rd_word;
   logic        rx_empty, rx_full;
   logic [3:0]  rx_stat;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   uart_rx_tagfifo #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .push_stb(push_stb),
      .push_char(push_char), .push_frm(push_frm), .push_par(push_par),
      .push_brk(push_brk), .pop_stb(pop_stb), .clr_stat(clr_stat),
      .rd_word(rd_word), .rx_empty(rx_empty), .rx_full(rx_full),
      .rx_stat(rx_stat)
   );

   typedef struct packed {
      logic        psh;
      logic [7:0]  ch;
      logic        f, p, b;
      logic        pop, clr;
      logic [11:0] word;
      logic        emp, ful;
      logic [3:0]  st;
   } vec_t;

   // Stimulus and expectations, buffer enabled, DEPTH = 4.
   localparam vec_t VEC [18] = '{
      '{1'b1, 8'h41, 1'b0,1'b0,1'b0, 1'b0,1'b0, 12'h000, 1'b0,1'b0, 4'h0},
      '{1'b1, 8'h42, 1'b1,1'b0,1'b0, 1'b0,1'b0, 12'h000, 1'b0,1'b0, 4'h1},
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h041, 1'b0,1'b0, 4'h1},
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h142, 1'b1,1'b0, 4'h1},
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h142, 1'b1,1'b0, 4'h1}, // R5
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b0,1'b1, 12'h142, 1'b1,1'b0, 4'h0}, // R7
      '{1'b1, 8'h55, 1'b0,1'b1,1'b0, 1'b0,1'b0, 12'h142, 1'b0,1'b0, 4'h2},
      '{1'b1, 8'h66, 1'b0,1'b0,1'b1, 1'b0,1'b0, 12'h142, 1'b0,1'b0, 4'h6},
      '{1'b1, 8'h77, 1'b0,1'b0,1'b0, 1'b0,1'b0, 12'h142, 1'b0,1'b0, 4'h6},
      '{1'b1, 8'h88, 1'b0,1'b0,1'b0, 1'b0,1'b0, 12'h142, 1'b0,1'b1, 4'h6},
      '{1'b1, 8'h99, 1'b1,1'b0,1'b0, 1'b0,1'b0, 12'h142, 1'b0,1'b1, 4'hE}, // R4
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h255, 1'b0,1'b0, 4'hE},
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h466, 1'b0,1'b0, 4'hE},
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h077, 1'b0,1'b0, 4'hE},
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h888, 1'b1,1'b0, 4'hE}, // R4 tag
      '{1'b1, 8'h12, 1'b0,1'b1,1'b0, 1'b0,1'b1, 12'h888, 1'b0,1'b0, 4'h2}, // R7
      '{1'b1, 8'h34, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h212, 1'b0,1'b0, 4'h2},
      '{1'b0, 8'h00, 1'b0,1'b0,1'b0, 1'b1,1'b0, 12'h034, 1'b1,1'b0, 4'h2}
   };

   task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(input logic psh, input logic [7:0] ch, input logic f,
                       input logic p, input logic b, input logic pop, input logic clr);
      @(negedge clk);
      push_stb = psh; push_char = ch; push_frm = f; push_par = p; push_brk = b;
      pop_stb = pop; clr_stat = clr;
      @(posedge clk);
      #1;
      push_stb = 1'b0; pop_stb = 1'b0; clr_stat = 1'b0;
      push_frm = 1'b0; push_par = 1'b0; push_brk = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10 reset state
      chk("R10 word", rd_word, 12'h000);
      chk("R10 empty", 12'(rx_empty), 12'h1);
      chk("R10 full", 12'(rx_full), 12'h0);
      chk("R10 stat", 12'(rx_stat), 12'h0);

      // Table walk: R1 word layout, R2 order, R3 flags, R6 status.
      for (int i = 0; i < 18; i++) begin
         step(VEC[i].psh, VEC[i].ch, VEC[i].f, VEC[i].p, VEC[i].b, VEC[i].pop, VEC[i].clr);
         chk($sformatf("R1 R2 word row %0d", i), rd_word, VEC[i].word);
         chk($sformatf("R3 empty row %0d", i), 12'(rx_empty), 12'(VEC[i].emp));
         chk($sformatf("R3 full row %0d", i), 12'(rx_full), 12'(VEC[i].ful));
         chk($sformatf("R6 stat row %0d", i), 12'(rx_stat), 12'(VEC[i].st));
      end

      // R8: buffer off, one entry only; second push overruns onto it.
      do_reset();
      fifo_on = 1'b0;
      step(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8 full after one", 12'(rx_full), 12'h1);
      chk("R8 not empty", 12'(rx_empty), 12'h0);
      step(1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R4 R8 overrun status", 12'(rx_stat), 12'h8);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R4 R8 tagged word", rd_word, 12'h85A);
      chk("R8 empty after read", 12'(rx_empty), 12'h1);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R5 R8 dropped char not stored", rd_word, 12'h85A);
      fifo_on = 1'b1;

      // R9: full with push and pop together.
      do_reset();
      for (int k = 1; k <= DEPTH; k++)
         step(1'b1, 8'(k), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R2 full at DEPTH", 12'(rx_full), 12'h1);
      step(1'b1, 8'hC5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R9 word", rd_word, 12'h001);
      chk("R9 still full", 12'(rx_full), 12'h1);
      chk("R9 no overrun", 12'(rx_stat), 12'h0);
      for (int k = 2; k <= DEPTH; k++) begin
         step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
         chk("R2 drain order", rd_word, 12'(k));
      end
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R9 pushed char kept", rd_word, 12'h0C5);
      chk("R3 empty after drain", 12'(rx_empty), 12'h1);

      finish_run();
   end
endmodule